// File: doc/BRIEF.md
# Link Replay Timer and Counter

This block watches acknowledgement timeliness on the transmit side of a link layer. Each time the last symbol of a packet (new or retransmitted) leaves the transmitter, a timer restarts from zero against a programmable limit captured at that moment. If no acknowledgement or negative acknowledgement comes back before the limit is reached, the block asks for a replay of the unacknowledged packets. A received NAK is the other replay cause.

Every replay is counted. An acknowledgement that retires new packets clears the count. When a replay cause arrives while the count already stands at its ceiling (three by default), the block gives up on replaying. It pulses a retrain request to the physical layer and waits for retrain completion. On completion it clears the count and issues the postponed replay. The block does not handle sequence numbers or packet storage. It only times and counts.

Top module: `link_replay_supervisor`

## Requirements
- R1: After reset, replay_req_o and retrain_req_o are low and replay_cnt_o is 0.
- R2: A pulse on pkt_sent_i restarts the timer at zero with limit L taken from timeout_limit_i. If nothing else happens, replay_req_o is high for exactly one cycle, L+1 clock cycles after the edge that sampled pkt_sent_i.
- R3: timeout_limit_i is sampled only when the timer starts. Changing it while the timer runs does not move the timeout.
- R4: ack_i resets the timer to zero and lets it run on while outstanding_i is high. The timeout then falls L+1 cycles after the ACK edge. An ACK in the same cycle as a timeout suppresses that timeout.
- R5: nak_i raises replay_req_o for one cycle, in the cycle after it is sampled, and stops the timer until the next pkt_sent_i.
- R6: A NAK in the same cycle as a timeout gives a single one-cycle replay request and raises replay_cnt_o by exactly 1.
- R7: While outstanding_i is low, the timer is held at zero and stopped, and no timeout replay is raised, even after pkt_sent_i.
- R8: replay_cnt_o rises by 1 with each issued replay and returns to 0 on ack_i.
- R9: A replay cause that arrives with replay_cnt_o at 3 gives a one-cycle retrain_req_o pulse instead of a replay request, and replay_cnt_o stays at 3. Further NAKs are ignored until retrain completes.
- R10: retrain_done_i clears replay_cnt_o. If a retrain is pending, replay_req_o goes high for one cycle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_sent_i | input | 1 | Last symbol of a packet or retransmission sent |
| ack_i | input | 1 | ACK received that acknowledges new packets |
| nak_i | input | 1 | NAK received |
| outstanding_i | input | 1 | Unacknowledged packets exist |
| timeout_limit_i | input | 16 | Timeout limit in cycles |
| retrain_done_i | input | 1 | Physical layer has finished retraining |
| replay_req_o | output | 1 | One-cycle replay request |
| retrain_req_o | output | 1 | One-cycle retrain request |
| replay_cnt_o | output | 2 | Replays issued since last ACK or retrain |

## Verification
A timeout and a NAK can both fall in the same cycle. The bench provokes this by starting the timer with a known limit, counting cycles to the one in which the timer sits at its limit, and driving a NAK for exactly that cycle. The result is accepted only if replay_req_o is high for a single cycle and replay_cnt_o has advanced by one, not two. An ACK that lands on the timeout cycle is also covered, through the ACK restart check.

// File: rtl/link_replay_pkg.sv
package link_replay_pkg;
  localparam int unsigned LIMIT_W_DEF    = 16;
  localparam int unsigned MAX_REPLAY_DEF = 3;
endpackage

// File: rtl/replay_timer.sv
module replay_timer #(
  parameter int unsigned LIMIT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               ack_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               expire_o
);
  logic               run_q;
  logic [LIMIT_W-1:0] cnt_q;
  logic [LIMIT_W-1:0] lim_q;

  assign expire_o = run_q && (cnt_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
    end else if (hold_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (stop_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (ack_i) begin
      cnt_q <= '0;
    end else if (expire_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_hold_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !expire_o);
  assert_stop_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !expire_o);
  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q <= lim_q);
endmodule

// File: rtl/replay_counter.sv
module replay_counter #(
  parameter int unsigned MAX_REPLAY = 3,
  localparam int unsigned CNT_W = $clog2(MAX_REPLAY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cause_i,
  input  logic             ack_i,
  input  logic             retrain_done_i,
  output logic             replay_o,
  output logic             retrain_o,
  output logic             pending_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             pending_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;
  logic             ev;

  assign ev        = cause_i && !pending_q;
  assign base      = ack_i ? '0 : cnt_q;
  assign pending_o = pending_q;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      cnt_q     <= '0;
      replay_o  <= 1'b0;
      retrain_o <= 1'b0;
    end else begin
      replay_o  <= 1'b0;
      retrain_o <= 1'b0;
      if (retrain_done_i) begin
        cnt_q     <= '0;
        pending_q <= 1'b0;
        replay_o  <= pending_q;
      end else if (ev) begin
        if (base == CNT_W'(MAX_REPLAY)) begin
          retrain_o <= 1'b1;
          pending_q <= 1'b1;
          cnt_q     <= base;
        end else begin
          replay_o <= 1'b1;
          cnt_q    <= base + 1'b1;
        end
      end else begin
        cnt_q <= base;
      end
    end
  end

  assert_single_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({replay_o, retrain_o}));
  assert_retrain_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retrain_o |=> !retrain_o);
  assert_retrain_at_max_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pending_q) |-> cnt_q == CNT_W'(MAX_REPLAY));
  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_REPLAY));
  assert_done_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retrain_done_i |=> (cnt_q == '0) && !pending_q);
endmodule

// File: rtl/link_replay_supervisor.sv
module link_replay_supervisor
  import link_replay_pkg::*;
#(
  parameter int unsigned LIMIT_W    = LIMIT_W_DEF,
  parameter int unsigned MAX_REPLAY = MAX_REPLAY_DEF,
  localparam int unsigned CNT_W = $clog2(MAX_REPLAY + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pkt_sent_i,
  input  logic               ack_i,
  input  logic               nak_i,
  input  logic               outstanding_i,
  input  logic [LIMIT_W-1:0] timeout_limit_i,
  input  logic               retrain_done_i,
  output logic               replay_req_o,
  output logic               retrain_req_o,
  output logic [CNT_W-1:0]   replay_cnt_o
);
  logic expire;
  logic pending;
  logic cause;

  replay_timer #(.LIMIT_W(LIMIT_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (!outstanding_i || pending),
    .start_i  (pkt_sent_i),
    .stop_i   (nak_i),
    .ack_i    (ack_i),
    .limit_i  (timeout_limit_i),
    .expire_o (expire)
  );

  // an ACK in the expiry cycle wins over the timeout
  assign cause = nak_i || (expire && !ack_i);

  replay_counter #(.MAX_REPLAY(MAX_REPLAY)) i_counter (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cause_i        (cause),
    .ack_i          (ack_i),
    .retrain_done_i (retrain_done_i),
    .replay_o       (replay_req_o),
    .retrain_o      (retrain_req_o),
    .pending_o      (pending),
    .cnt_o          (replay_cnt_o)
  );

  assert_req_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (replay_req_o && !$past(retrain_done_i)) |=> !replay_req_o);
  assert_req_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_req_o |-> $past(nak_i || expire || retrain_done_i));
endmodule

// File: tb/test_link_replay_supervisor.sv
`timescale 1ns/1ps
module test_link_replay_supervisor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sent = 1'b0, ack = 1'b0, nak = 1'b0, outst = 1'b0, done = 1'b0;
  logic [15:0] limit = 16'd8;
  logic        replay, retrain;
  logic [1:0]  cnt;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  link_replay_supervisor i_link_replay_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .pkt_sent_i(sent), .ack_i(ack), .nak_i(nak),
    .outstanding_i(outst), .timeout_limit_i(limit), .retrain_done_i(done),
    .replay_req_o(replay), .retrain_req_o(retrain), .replay_cnt_o(cnt));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_sent();
    @(negedge clk); sent = 1'b1; @(negedge clk); sent = 1'b0;
  endtask
  task automatic pulse_nak();
    @(negedge clk); nak = 1'b1; @(negedge clk); nak = 1'b0;
  endtask
  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic quiesce();
    outst = 1'b0; pulse_ack(); wait_n(2); outst = 1'b1;
  endtask

  task automatic t_reset_R1();
    chk(replay == 0 && retrain == 0, "R1 reqs", {replay, retrain}, 0);
    chk(cnt == 0, "R1 cnt", cnt, 0);
  endtask

  task automatic t_timeout_R2();
    limit = 16'd8; pulse_sent();
    wait_n(8);
    chk(replay == 0, "R2 early", replay, 0);
    wait_n(1);
    chk(replay == 1, "R2 fire", replay, 1);
    chk(cnt == 1, "R8 count up", cnt, 1);
    wait_n(1);
    chk(replay == 0, "R2 one cycle", replay, 0);
    quiesce();
  endtask

  task automatic t_sampled_R3();
    int hit = 0;
    limit = 16'd10; pulse_sent(); limit = 16'd3;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (replay) hit++; end
    chk(hit == 0, "R3 no early", hit, 0);
    wait_n(1);
    chk(replay == 1, "R3 fire at sampled", replay, 1);
    quiesce();
  endtask

  task automatic t_ack_R4();
    limit = 16'd6; pulse_sent(); wait_n(3);
    pulse_ack();
    wait_n(6);
    chk(replay == 0, "R4 restarted", replay, 0);
    wait_n(1);
    chk(replay == 1, "R4 fire after ack", replay, 1);
    quiesce();
    // ACK in the expiry cycle
    limit = 16'd4; pulse_sent(); wait_n(4);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk(replay == 0, "R4 ack suppresses", replay, 0);
    quiesce();
  endtask

  task automatic t_nak_R5();
    limit = 16'd5; pulse_sent(); wait_n(1);
    pulse_nak();
    chk(replay == 1, "R5 nak replay", replay, 1);
    wait_n(1);
    chk(replay == 0, "R5 pulse", replay, 0);
    wait_n(10);
    chk(replay == 0, "R5 timer stopped", replay, 0);
    quiesce();
  endtask

  task automatic t_collide_R6();
    limit = 16'd5; pulse_sent(); wait_n(5);
    nak = 1'b1; @(negedge clk); nak = 1'b0;
    chk(replay == 1, "R6 one req", replay, 1);
    chk(cnt == 1, "R6 single increment", cnt, 1);
    wait_n(1);
    chk(replay == 0, "R6 not repeated", replay, 0);
    quiesce();
  endtask

  task automatic t_hold_R7();
    int hit = 0;
    outst = 1'b0; limit = 16'd2; pulse_sent();
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (replay) hit++; end
    chk(hit == 0, "R7 held", hit, 0);
    outst = 1'b1;
  endtask

  task automatic t_escalate_R9_R10();
    pulse_nak(); pulse_nak();
    chk(cnt == 2, "R8 count two", cnt, 2);
    pulse_ack();
    chk(cnt == 0, "R8 ack clears", cnt, 0);
    pulse_nak(); pulse_nak(); pulse_nak();
    chk(cnt == 3, "R8 count three", cnt, 3);
    pulse_nak();
    chk(retrain == 1 && replay == 0, "R9 retrain not replay", {retrain, replay}, 2);
    chk(cnt == 3, "R9 count holds", cnt, 3);
    wait_n(1);
    chk(retrain == 0, "R9 pulse", retrain, 0);
    pulse_nak();
    chk(replay == 0 && retrain == 0, "R9 ignored while pending", {retrain, replay}, 0);
    @(negedge clk); done = 1'b1; @(negedge clk); done = 1'b0;
    chk(replay == 1, "R10 retry after retrain", replay, 1);
    chk(cnt == 0, "R10 count cleared", cnt, 0);
    pulse_nak();
    chk(cnt == 1 && replay == 1, "R10 normal again", cnt, 1);
    quiesce();
  endtask

  initial begin : watchdog
    #400us;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_n(3);
    t_reset_R1();
    rst_n = 1'b1; outst = 1'b1;
    wait_n(2);
    t_reset_R1();
    t_timeout_R2();
    t_sampled_R3();
    t_ack_R4();
    t_nak_R5();
    t_collide_R6();
    t_hold_R7();
    t_escalate_R9_R10();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule